// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block sits beside the register file of a PC-compatible serial port. It collects the five interrupt causes of the port, ranks them by a fixed priority, and presents two results. The first is the encoded identification byte that software reads. The second is a level interrupt line toward the system interrupt controller.

The causes are receiver line status errors, a receive character timeout, receive data available, transmit holding register empty and modem status change. The receive data cause takes the FIFO trigger level into account when the FIFOs are on. With the FIFOs off, the data-ready bit alone raises it.

The block holds the transmitter-empty pending flag itself. The surrounding register logic sends it four simple strobes. A write to the holding register clears the flag. The holding register going empty sets it. A read of the identification register clears it. A write to the enable register while the holding register is empty sets it again.

Top module: `uirq_top`

## Requirements
- R1: After reset the transmit-empty pending flag is clear. With FIFOs off and no cause active, `iidOut` reads 0x01 and `irqOut` is low.
- R2: When `ierIn[2]` is set and any bit of `lineErr` (overrun, parity, framing, break) is set, the low nibble of `iidOut` is 0x6. This cause outranks every other cause.
- R3: When `timeoutPend` is high and no enabled line status cause is active, the low nibble is 0xC. This cause outranks receive data, and no enable bit gates it.
- R4: When `ierIn[0]` is set and `dataReady` is high, the low nibble is 0x4, provided no higher cause is active. With `fifoOn` low, `dataReady` alone raises the cause. With `fifoOn` high, the cause needs `rxCount` >= `rxTrigger` as well. A receive cause below the trigger level does not block lower causes.
- R5: When `ierIn[1]` is set and the transmit-empty pending flag is set, the low nibble is 0x2, provided no higher cause is active.
- R6: When `ierIn[3]` is set and any bit of `msrDelta` is set, the low nibble is 0x0, provided no higher cause is active.
- R7: When no cause is active, the low nibble is 0x1.
- R8: Bits 7:6 of `iidOut` are both 1 while `fifoOn` is high and both 0 otherwise. Bits 5:4 always read 0.
- R9: `irqOut` is high exactly when `ierIn` is nonzero and the low nibble differs from 0x1. When `ierIn` is zero, `irqOut` stays low even while a timeout shows 0xC.
- R10: On the clock after `thrEmpty` rises, the pending flag is set. On the clock after a `txLoad` strobe, the flag is cleared, and this clear takes precedence over every setting event in the same cycle.
- R11: An `iidRead` strobe clears the pending flag on the next clock, unless a setting event occurs in the same cycle.
- R12: An `ierWrite` strobe while `thrEmpty` is high sets the pending flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ierIn | input | 4 | Interrupt enable: [0] rx data, [1] tx empty, [2] line status, [3] modem |
| lineErr | input | 4 | Line error bits: overrun, parity, framing, break |
| dataReady | input | 1 | Receive data ready |
| timeoutPend | input | 1 | Character timeout pending |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigger | input | CNT_W | Receive FIFO trigger level |
| thrEmpty | input | 1 | Transmit holding register empty status |
| msrDelta | input | 4 | Modem status delta bits |
| fifoOn | input | 1 | FIFOs enabled |
| txLoad | input | 1 | Strobe: holding register written |
| ierWrite | input | 1 | Strobe: enable register written |
| iidRead | input | 1 | Strobe: identification register read |
| iidOut | output | 8 | Identification byte |
| irqOut | output | 1 | Interrupt request level |

## Verification
The identification byte and the interrupt line are combinational in the present inputs and the pending flag. A change on a status input therefore appears in the same cycle. The bench drives each vector on the falling edge and compares it just before the next rising edge. The strobes act on the pending flag at the rising edge, so their effect is due one vector later. The bench reference model updates its own flag copy at that edge, and the following vector carries the new expectation. The queue pairs each expected item with the vector that produced it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC = 5;

  localparam logic [3:0] CODE_LINE  = 4'h6;
  localparam logic [3:0] CODE_TMO   = 4'hC;
  localparam logic [3:0] CODE_RXD   = 4'h4;
  localparam logic [3:0] CODE_TXE   = 4'h2;
  localparam logic [3:0] CODE_MODEM = 4'h0;
  localparam logic [3:0] CODE_NONE  = 4'h1;

  typedef struct packed {
    logic setTx;
    logic clrTx;
  } txEvt_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   thrEmpty,
  input  logic   txLoad,
  input  logic   ierWrite,
  input  logic   iidRead,
  output txEvt_t evt
);
  logic prevEmpty;
  logic emptyRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEmpty <= 1'b1;
    else       prevEmpty <= thrEmpty;
  end

  assign emptyRise = thrEmpty && !prevEmpty;

  always_comb begin
    evt.setTx = !txLoad && ((ierWrite && thrEmpty) || emptyRise);
    evt.clrTx = txLoad || iidRead;
  end

  AST_LOAD_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> !evt.setTx); // R10
endmodule

// File: rtl/uirq_dpath.sv
module uirq_dpath
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ierIn,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             timeoutPend,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic [3:0]       msrDelta,
  input  logic             fifoOn,
  input  txEvt_t           evt,
  output logic             txPend,
  output logic [7:0]       iidOut,
  output logic             irqOut
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [3:0]         srcCode [NUM_SRC];
  logic [3:0]         lowCode;
  logic               rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txPend <= 1'b0;
    else if (evt.setTx) txPend <= 1'b1;
    else if (evt.clrTx) txPend <= 1'b0;
  end

  assign rxReady = dataReady && (!fifoOn || (rxCount >= rxTrigger));

  // index 0 is the highest priority
  always_comb begin
    req[0] = ierIn[2] && (|lineErr);
    req[1] = timeoutPend;
    req[2] = ierIn[0] && rxReady;
    req[3] = ierIn[1] && txPend;
    req[4] = ierIn[3] && (|msrDelta);
    srcCode[0] = CODE_LINE;
    srcCode[1] = CODE_TMO;
    srcCode[2] = CODE_RXD;
    srcCode[3] = CODE_TXE;
    srcCode[4] = CODE_MODEM;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_grant
      if (gi == 0) begin : g_top
        assign grant[gi] = req[gi];
      end else begin : g_low
        assign grant[gi] = req[gi] && !(|req[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    lowCode = CODE_NONE;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) lowCode = srcCode[i];
  end

  assign iidOut = {fifoOn, fifoOn, 2'b00, lowCode};
  assign irqOut = (ierIn != 4'h0) && (lowCode != CODE_NONE);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R7
  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ierIn[2] && |lineErr) |-> iidOut[3:0] == CODE_LINE); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ierIn == 4'h0) |-> !irqOut); // R9
  AST_REARM: assert property (@(posedge clk) disable iff (!rstN)
    evt.setTx |=> txPend); // R12
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (evt.clrTx && !evt.setTx) |=> !txPend); // R11
endmodule

// File: rtl/uirq_top.sv
module uirq_top
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ierIn,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             timeoutPend,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             thrEmpty,
  input  logic [3:0]       msrDelta,
  input  logic             fifoOn,
  input  logic             txLoad,
  input  logic             ierWrite,
  input  logic             iidRead,
  output logic [7:0]       iidOut,
  output logic             irqOut
);
  txEvt_t evt;
  logic   txPend;

  uirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .thrEmpty(thrEmpty), .txLoad(txLoad),
    .ierWrite(ierWrite), .iidRead(iidRead), .evt(evt)
  );

  uirq_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ierIn(ierIn), .lineErr(lineErr),
    .dataReady(dataReady), .timeoutPend(timeoutPend), .rxCount(rxCount),
    .rxTrigger(rxTrigger), .msrDelta(msrDelta), .fifoOn(fifoOn),
    .evt(evt), .txPend(txPend), .iidOut(iidOut), .irqOut(irqOut)
  );

  AST_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    iidOut[5:4] == 2'b00); // R8
endmodule

// File: tb/tb_uirq_top.sv
module tb_uirq_top;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] ierIn = '0, lineErr = '0, msrDelta = '0;
  logic dataReady = 0, timeoutPend = 0, thrEmpty = 1, fifoOn = 0;
  logic txLoad = 0, ierWrite = 0, iidRead = 0;
  logic [CNT_W-1:0] rxCount = '0, rxTrigger = '0;
  logic [7:0] iidOut;
  logic irqOut;

  // shadow inputs, applied at the falling edge
  logic [3:0] nIer = '0, nErr = '0, nDelta = '0;
  logic nDr = 0, nTmo = 0, nEmpty = 1, nFifo = 0;
  logic nLoad = 0, nIerWr = 0, nRd = 0;
  logic [CNT_W-1:0] nCnt = '0, nTrig = '0;

  // bench model of the pending flag
  logic mPend = 0, mPrev = 1;

  typedef struct { logic [7:0] iid; logic irq; string tag; } item_t;
  item_t sbq[$];

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uirq_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .ierIn(ierIn), .lineErr(lineErr),
    .dataReady(dataReady), .timeoutPend(timeoutPend), .rxCount(rxCount),
    .rxTrigger(rxTrigger), .thrEmpty(thrEmpty), .msrDelta(msrDelta),
    .fifoOn(fifoOn), .txLoad(txLoad), .ierWrite(ierWrite), .iidRead(iidRead),
    .iidOut(iidOut), .irqOut(irqOut)
  );

  function automatic logic [3:0] expCode();
    if (nIer[2] && |nErr) return 4'h6;
    if (nTmo) return 4'hC;
    if (nIer[0] && nDr && (!nFifo || nCnt >= nTrig)) return 4'h4;
    if (nIer[1] && mPend) return 4'h2;
    if (nIer[3] && |nDelta) return 4'h0;
    return 4'h1;
  endfunction

  task automatic step(input string tag);
    item_t it;
    logic [3:0] c;
    @(negedge clk);
    ierIn = nIer; lineErr = nErr; msrDelta = nDelta; dataReady = nDr;
    timeoutPend = nTmo; thrEmpty = nEmpty; fifoOn = nFifo; txLoad = nLoad;
    ierWrite = nIerWr; iidRead = nRd; rxCount = nCnt; rxTrigger = nTrig;
    c = expCode();
    it.iid = {nFifo, nFifo, 2'b00, c};
    it.irq = (nIer != 0) && (c != 4'h1);
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    if (nLoad) mPend = 0;
    else if ((nIerWr && nEmpty) || (nEmpty && !mPrev)) mPend = 1;
    else if (nRd) mPend = 0;
    mPrev = nEmpty;
    nLoad = 0; nIerWr = 0; nRd = 0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks++;
        if (iidOut !== it.iid || irqOut !== it.irq) begin
          fails++;
          $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                   it.tag, iidOut, irqOut, it.iid, it.irq);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rstN = 1;
    step("R1 reset idle");
    step("R7 idle no cause");
    // line status
    nIer = 4'h4; nErr = 4'b0010;
    step("R2 line status");
    nIer = 4'hF; nTmo = 1; nDr = 1; nDelta = 4'h1; nErr = 4'b1000;
    step("R2 line status over all");
    nErr = 0;
    step("R3 timeout over rx data");
    nIer = 0;
    step("R3 R9 timeout ungated irq low");
    nTmo = 0; nDelta = 0; nIer = 4'h1;
    step("R4 rx data fifo off");
    nFifo = 1; nCnt = 3; nTrig = 4;
    step("R4 R8 fifo below trigger");
    nCnt = 4;
    step("R4 R8 fifo at trigger");
    nDr = 0; nFifo = 0; nCnt = 0;
    // transmit empty via enable write
    nIer = 4'h2; nIerWr = 1;
    step("R12 enable write cycle");
    step("R12 R5 tx empty pending");
    nRd = 1;
    step("R11 read cycle");
    step("R11 cleared by read");
    // holding write then empty again
    nEmpty = 0; nLoad = 1;
    step("R10 load cycle");
    step("R10 not empty");
    nEmpty = 1;
    step("R10 empty rise cycle");
    step("R10 pending after rise");
    // below-trigger rx does not block tx
    nIer = 4'h3; nFifo = 1; nDr = 1; nCnt = 1; nTrig = 8;
    step("R4 below trigger falls through");
    nDelta = 4'h4; nIer = 4'hA;
    step("R5 tx over modem");
    nLoad = 1;
    step("R10 load clears");
    nFifo = 0; nDr = 0;
    step("R6 modem status");
    nIer = 4'h0;
    step("R9 disabled irq low");
    step("R9 drain");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule